// File: doc/BRIEF.md
# SPI FIFO Threshold Interrupt Unit

This unit is the status and interrupt logic that sits next to the transmit and receive FIFOs of an SPI controller. It tracks how many entries each FIFO holds and compares those counts against two programmable thresholds. It raises sticky error flags when software or the shift engine misuses a FIFO. It folds all sources through a mask into a single registered interrupt line. The FIFO storage, the shift engine and the register decoder live elsewhere. Single-cycle push and pop strobes stand in for them here: software writes and reads of the data register, and frames moved by the shift engine.

The threshold registers hold only as many bits as the FIFO depth needs, and the bits above that read back as zero. Software can therefore find the depth by writing rising values and noting the first one that does not read back unchanged. Raw status and masked status are separate outputs. Error flags are cleared by a one-cycle read strobe on a clear register, or by dropping the core enable.

Top module: `spi_fifo_irq`

## Requirements
- R1: After reset both levels, both thresholds, the mask, every error flag and `irq` are zero.
- R2: A level rises by one on an accepted push and falls by one on an accepted pop. A push and a pop accepted in the same cycle leave it unchanged. A transmit pop on an empty FIFO is ignored and raises no flag.
- R3: Status bit 0 (transmit empty) is 1 in every cycle in which the transmit level is at or below the transmit threshold, even if nothing was pushed since it was last seen.
- R4: Status bit 4 (receive full) is 1 exactly when the receive level is greater than the receive threshold, so a threshold of N-1 signals once N entries are held.
- R5: A transmit push while the transmit level equals DEPTH is discarded and sets status bit 1 (transmit overflow).
- R6: A receive push while the receive level equals DEPTH drops the frame and sets status bit 3 (receive overflow).
- R7: A receive pop while the receive level is zero leaves the level at zero and sets status bit 2 (receive underflow).
- R8: Error bits 1, 2 and 3 stay set until a cycle with `errClrRd` high or with `enable` low. An error event in the same cycle as `errClrRd` leaves its bit set.
- R9: Each threshold keeps only its low clog2(DEPTH) bits of `thrWrData`, and the higher readback bits are zero. With DEPTH=16, the first rising probe value that does not read back unchanged is 16.
- R10: `maskedStatus` is `rawStatus` ANDed bit by bit with the last value written through `maskWr`.
- R11: `irq` is high in the cycle after any `maskedStatus` bit is high, and low in the cycle after none is.
- R12: While `enable` is low, both levels go to zero, pushes and pops are ignored, and the thresholds and mask keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Core enable; low flushes levels and clears errors |
| txPush | input | 1 | Software write to the transmit data register |
| txPop | input | 1 | Shift engine takes a transmit frame |
| rxPush | input | 1 | Shift engine delivers a received frame |
| rxPop | input | 1 | Software read of the receive data register |
| txThrWr | input | 1 | Write strobe for the transmit threshold |
| rxThrWr | input | 1 | Write strobe for the receive threshold |
| thrWrData | input | 8 | Threshold write value |
| maskWr | input | 1 | Write strobe for the mask |
| maskWrData | input | 5 | Mask write value, same bit order as the status |
| errClrRd | input | 1 | Read of the error clear register |
| txLevel | output | clog2(DEPTH+1) | Transmit entry count |
| rxLevel | output | clog2(DEPTH+1) | Receive entry count |
| txThrRd | output | 8 | Transmit threshold readback |
| rxThrRd | output | 8 | Receive threshold readback |
| rawStatus | output | 5 | Unmasked status bits |
| maskedStatus | output | 5 | Status after the mask |
| irq | output | 1 | Registered interrupt line |

## Verification
The hardest situations to reach are the ones where an error event meets its own clear, or where a push reaches a full FIFO in the same cycle as a pop. Directed sequences fill each FIFO past DEPTH and then pulse the clear strobe while another overflowing push is in flight. A long pseudo-random phase then mixes every strobe, threshold and mask write with occasional enable drops. Each cycle is compared against a behavioural model kept in plain integers. The depth probe writes every value from 1 to 255 and checks where the readback first diverges.

// File: rtl/spi_fifo_irq_pkg.sv
package spi_fifo_irq_pkg;
  localparam int THR_REG_W = 8;
  localparam int STAT_W    = 5;
  // status bit positions, shared by raw status, mask and masked status
  localparam int B_TXEMPTY = 0;
  localparam int B_TXOVF   = 1;
  localparam int B_RXUND   = 2;
  localparam int B_RXOVF   = 3;
  localparam int B_RXFULL  = 4;
  // channel indices
  localparam int CH_TX = 0;
  localparam int CH_RX = 1;

  typedef struct packed {
    logic [1:0] inc;
    logic [1:0] dec;
    logic       flush;
  } lvlCtl_t;
endpackage

// File: rtl/sfi_level_ctr.sv
module sfi_level_ctr #(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             inc,
  input  logic             dec,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              level <= '0;
    else if (flush)         level <= '0;
    else if (inc && !dec)   level <= level + 1'b1;
    else if (dec && !inc)   level <= level - 1'b1;
  end

  assign full  = (level == LVL_W'(DEPTH));
  assign empty = (level == '0);
endmodule

// File: rtl/sfi_datapath.sv
module sfi_datapath
  import spi_fifo_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int THR_W = $clog2(DEPTH)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  lvlCtl_t                         ctl,
  input  logic [1:0]                      thrWr,
  input  logic [THR_REG_W-1:0]            thrWrData,
  output logic [1:0][LVL_W-1:0]           level,
  output logic [1:0]                      full,
  output logic [1:0]                      empty,
  output logic [1:0][THR_REG_W-1:0]       thrRd,
  output logic [1:0]                      thrHit
);
  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [THR_W-1:0] thr;

    sfi_level_ctr #(.DEPTH(DEPTH)) u_ctr (
      .clk   (clk),
      .rstN  (rstN),
      .flush (ctl.flush),
      .inc   (ctl.inc[c]),
      .dec   (ctl.dec[c]),
      .level (level[c]),
      .full  (full[c]),
      .empty (empty[c])
    );

    // only the bits a level comparison can use are stored
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         thr <= '0;
      else if (thrWr[c]) thr <= thrWrData[THR_W-1:0];
    end

    assign thrRd[c] = THR_REG_W'(thr);

    if (c == CH_TX) begin : g_tx_cmp
      assign thrHit[c] = (level[c] <= LVL_W'(thr));
    end else begin : g_rx_cmp
      assign thrHit[c] = (level[c] > LVL_W'(thr));
    end
  end
endmodule

// File: rtl/sfi_ctrl.sv
module sfi_ctrl
  import spi_fifo_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              txPush,
  input  logic              txPop,
  input  logic              rxPush,
  input  logic              rxPop,
  input  logic              errClrRd,
  input  logic              maskWr,
  input  logic [STAT_W-1:0] maskWrData,
  input  logic [1:0]        full,
  input  logic [1:0]        empty,
  input  logic [1:0]        thrHit,
  output lvlCtl_t           ctl,
  output logic [STAT_W-1:0] rawStatus,
  output logic [STAT_W-1:0] maskedStatus,
  output logic              irq
);
  logic txOvfEv, rxOvfEv, rxUndEv;
  logic txOvf, rxOvf, rxUnd;
  logic [STAT_W-1:0] mask;

  // acceptance decisions; a push to a full FIFO loses even when a pop
  // leaves in the same cycle
  always_comb begin
    ctl.flush      = !enable;
    ctl.inc[CH_TX] = enable && txPush && !full[CH_TX];
    ctl.dec[CH_TX] = enable && txPop  && !empty[CH_TX];
    ctl.inc[CH_RX] = enable && rxPush && !full[CH_RX];
    ctl.dec[CH_RX] = enable && rxPop  && !empty[CH_RX];
  end

  assign txOvfEv = enable && txPush && full[CH_TX];
  assign rxOvfEv = enable && rxPush && full[CH_RX];
  assign rxUndEv = enable && rxPop  && empty[CH_RX];

  // sticky errors: clear first, then a same-cycle event sets again
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txOvf <= 1'b0;
      rxOvf <= 1'b0;
      rxUnd <= 1'b0;
    end else if (!enable) begin
      txOvf <= 1'b0;
      rxOvf <= 1'b0;
      rxUnd <= 1'b0;
    end else begin
      txOvf <= (txOvf && !errClrRd) || txOvfEv;
      rxOvf <= (rxOvf && !errClrRd) || rxOvfEv;
      rxUnd <= (rxUnd && !errClrRd) || rxUndEv;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       mask <= '0;
    else if (maskWr) mask <= maskWrData;
  end

  always_comb begin
    rawStatus            = '0;
    rawStatus[B_TXEMPTY] = thrHit[CH_TX];
    rawStatus[B_TXOVF]   = txOvf;
    rawStatus[B_RXUND]   = rxUnd;
    rawStatus[B_RXOVF]   = rxOvf;
    rawStatus[B_RXFULL]  = thrHit[CH_RX];
  end

  assign maskedStatus = rawStatus & mask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= |maskedStatus;
  end
endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq
  import spi_fifo_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  logic                 txPush,
  input  logic                 txPop,
  input  logic                 rxPush,
  input  logic                 rxPop,
  input  logic                 txThrWr,
  input  logic                 rxThrWr,
  input  logic [7:0]           thrWrData,
  input  logic                 maskWr,
  input  logic [4:0]           maskWrData,
  input  logic                 errClrRd,
  output logic [LVL_W-1:0]     txLevel,
  output logic [LVL_W-1:0]     rxLevel,
  output logic [7:0]           txThrRd,
  output logic [7:0]           rxThrRd,
  output logic [4:0]           rawStatus,
  output logic [4:0]           maskedStatus,
  output logic                 irq
);
  lvlCtl_t ctl;
  logic [1:0][LVL_W-1:0]     level;
  logic [1:0][THR_REG_W-1:0] thrRd;
  logic [1:0]                full, empty, thrHit;

  sfi_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .thrWr     ({rxThrWr, txThrWr}),
    .thrWrData (thrWrData),
    .level     (level),
    .full      (full),
    .empty     (empty),
    .thrRd     (thrRd),
    .thrHit    (thrHit)
  );

  sfi_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .txPush       (txPush),
    .txPop        (txPop),
    .rxPush       (rxPush),
    .rxPop        (rxPop),
    .errClrRd     (errClrRd),
    .maskWr       (maskWr),
    .maskWrData   (maskWrData),
    .full         (full),
    .empty        (empty),
    .thrHit       (thrHit),
    .ctl          (ctl),
    .rawStatus    (rawStatus),
    .maskedStatus (maskedStatus),
    .irq          (irq)
  );

  assign txLevel = level[CH_TX];
  assign rxLevel = level[CH_RX];
  assign txThrRd = thrRd[CH_TX];
  assign rxThrRd = thrRd[CH_RX];
endmodule

// File: rtl/sfi_checker.sv
module sfi_checker #(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             txPush,
  input logic             txPop,
  input logic             rxPush,
  input logic             rxPop,
  input logic             errClrRd,
  input logic [LVL_W-1:0] txLevel,
  input logic [LVL_W-1:0] rxLevel,
  input logic [4:0]       rawStatus,
  input logic [4:0]       maskedStatus,
  input logic             irq
);
  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel <= LVL_W'(DEPTH)) && (rxLevel <= LVL_W'(DEPTH)));

  a_r5_tx_ovf: assert property (@(posedge clk) disable iff (!rstN)
    enable && txPush && !txPop && (txLevel == LVL_W'(DEPTH))
    |=> (txLevel == LVL_W'(DEPTH)) && rawStatus[1]);

  a_r6_rx_ovf: assert property (@(posedge clk) disable iff (!rstN)
    enable && rxPush && !rxPop && (rxLevel == LVL_W'(DEPTH))
    |=> (rxLevel == LVL_W'(DEPTH)) && rawStatus[3]);

  a_r7_rx_und: assert property (@(posedge clk) disable iff (!rstN)
    enable && rxPop && !rxPush && (rxLevel == '0)
    |=> (rxLevel == '0) && rawStatus[2]);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    enable && !errClrRd && rawStatus[1] |=> rawStatus[1]);

  a_r10_mask_subset: assert property (@(posedge clk) disable iff (!rstN)
    (maskedStatus & ~rawStatus) == 5'd0);

  a_r11_irq_rise: assert property (@(posedge clk) disable iff (!rstN)
    (|maskedStatus) |=> irq);

  a_r11_irq_fall: assert property (@(posedge clk) disable iff (!rstN)
    !(|maskedStatus) |=> !irq);

  a_r12_flush: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (txLevel == '0) && (rxLevel == '0) && (rawStatus[3:1] == 3'd0));
endmodule

bind spi_fifo_irq sfi_checker #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .enable       (enable),
  .txPush       (txPush),
  .txPop        (txPop),
  .rxPush       (rxPush),
  .rxPop        (rxPop),
  .errClrRd     (errClrRd),
  .txLevel      (txLevel),
  .rxLevel      (rxLevel),
  .rawStatus    (rawStatus),
  .maskedStatus (maskedStatus),
  .irq          (irq)
);

// File: tb/spi_fifo_irq_tb.sv
module spi_fifo_irq_tb;
  localparam int DEPTH = 16;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int THR_MASK = (1 << $clog2(DEPTH)) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic txPush = 0, txPop = 0, rxPush = 0, rxPop = 0;
  logic txThrWr = 0, rxThrWr = 0, maskWr = 0, errClrRd = 0;
  logic [7:0] thrWrData = '0;
  logic [4:0] maskWrData = '0;
  logic [LVL_W-1:0] txLevel, rxLevel;
  logic [7:0] txThrRd, rxThrRd;
  logic [4:0] rawStatus, maskedStatus;
  logic irq;

  always #4 clk = ~clk;

  spi_fifo_irq #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable),
    .txPush(txPush), .txPop(txPop), .rxPush(rxPush), .rxPop(rxPop),
    .txThrWr(txThrWr), .rxThrWr(rxThrWr), .thrWrData(thrWrData),
    .maskWr(maskWr), .maskWrData(maskWrData), .errClrRd(errClrRd),
    .txLevel(txLevel), .rxLevel(rxLevel), .txThrRd(txThrRd), .rxThrRd(rxThrRd),
    .rawStatus(rawStatus), .maskedStatus(maskedStatus), .irq(irq)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // behavioural reference state
  int mTx = 0, mRx = 0, mTxT = 0, mRxT = 0, mMask = 0;
  bit mTxO = 0, mRxO = 0, mRxU = 0, mIrq = 0;

  function automatic int modelRaw();
    int r = 0;
    if (mTx <= mTxT) r |= 1;
    if (mTxO)        r |= 2;
    if (mRxU)        r |= 4;
    if (mRxO)        r |= 8;
    if (mRx > mRxT)  r |= 16;
    return r;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic modelUpdate();
    bit evTxO, evRxO, evRxU;
    int nTx, nRx;
    if (!rstN) begin
      mTx = 0; mRx = 0; mTxT = 0; mRxT = 0; mMask = 0;
      mTxO = 0; mRxO = 0; mRxU = 0; mIrq = 0;
      return;
    end
    mIrq = ((modelRaw() & mMask) != 0);
    if (!enable) begin
      nTx = 0; nRx = 0;
      mTxO = 0; mRxO = 0; mRxU = 0;
    end else begin
      nTx = mTx; nRx = mRx;
      evTxO = txPush && (mTx == DEPTH);
      evRxO = rxPush && (mRx == DEPTH);
      evRxU = rxPop && (mRx == 0);
      if (txPush && mTx < DEPTH) nTx++;
      if (txPop && mTx > 0)      nTx--;
      if (rxPush && mRx < DEPTH) nRx++;
      if (rxPop && mRx > 0)      nRx--;
      if (errClrRd) begin mTxO = 0; mRxO = 0; mRxU = 0; end
      mTxO |= evTxO; mRxO |= evRxO; mRxU |= evRxU;
    end
    mTx = nTx; mRx = nRx;
    if (txThrWr) mTxT = thrWrData & THR_MASK;
    if (rxThrWr) mRxT = thrWrData & THR_MASK;
    if (maskWr)  mMask = maskWrData;
  endtask

  task automatic compareAll();
    int raw = modelRaw();
    check("R2 txLevel", txLevel, mTx);
    check("R2 rxLevel", rxLevel, mRx);
    check("R9 txThr", txThrRd, mTxT);
    check("R9 rxThr", rxThrRd, mRxT);
    check("R3 txEmpty bit", rawStatus[0], raw & 1);
    check("R5 txOvf bit", rawStatus[1], (raw >> 1) & 1);
    check("R7 rxUnd bit", rawStatus[2], (raw >> 2) & 1);
    check("R6 rxOvf bit", rawStatus[3], (raw >> 3) & 1);
    check("R4 rxFull bit", rawStatus[4], (raw >> 4) & 1);
    check("R10 masked", maskedStatus, raw & mMask);
    check("R11 irq", irq, mIrq);
  endtask

  task automatic tick();
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
    compareAll();
    txPush = 0; txPop = 0; rxPush = 0; rxPop = 0;
    txThrWr = 0; rxThrWr = 0; maskWr = 0; errClrRd = 0;
  endtask

  task automatic writeThr(bit rx, int v);
    thrWrData = 8'(v);
    if (rx) rxThrWr = 1; else txThrWr = 1;
    tick();
  endtask

  task automatic writeMask(int v);
    maskWrData = 5'(v); maskWr = 1; tick();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    int probe;
    int lfsr;
    repeat (2) @(negedge clk);
    // R1: reset values
    check("R1 txLevel", txLevel, 0);
    check("R1 rxLevel", rxLevel, 0);
    check("R1 thr", {txThrRd, rxThrRd}, 0);
    check("R1 errors", rawStatus[3:1], 0);
    check("R1 masked", maskedStatus, 0);
    check("R1 irq", irq, 0);
    rstN = 1; enable = 1;
    tick();

    writeMask(5'h1F);
    writeThr(0, 4);
    writeThr(1, 3);

    // R5 and R3: fill transmit past DEPTH
    for (int i = 0; i < DEPTH + 3; i++) begin txPush = 1; tick(); end
    check("R5 tx level held at DEPTH", txLevel, DEPTH);
    check("R5 tx overflow flag", rawStatus[1], 1);
    // full with push and pop together: push lost, pop taken
    txPush = 1; txPop = 1; tick();
    check("R5 push lost at full with pop", txLevel, DEPTH - 1);
    // R2: drain, then pop on empty
    for (int i = 0; i < DEPTH + 2; i++) begin txPop = 1; tick(); end
    check("R2 tx pop on empty ignored", txLevel, 0);
    check("R3 tx empty bit level-based", rawStatus[0], 1);
    tick();
    check("R3 tx empty still asserted", rawStatus[0], 1);

    // R4 and R6: fill receive past DEPTH
    for (int i = 0; i < 4; i++) begin rxPush = 1; tick(); end
    check("R4 rx full at thr+1 entries", rawStatus[4], 1);
    for (int i = 0; i < DEPTH; i++) begin rxPush = 1; tick(); end
    check("R6 rx overflow flag", rawStatus[3], 1);
    check("R6 rx level held", rxLevel, DEPTH);

    // R8: clear together with a new overflow keeps the bit
    errClrRd = 1; rxPush = 1; tick();
    check("R8 event beats clear", rawStatus[3], 1);
    check("R8 other errors cleared", rawStatus[1], 0);
    errClrRd = 1; tick();
    check("R8 clear read", rawStatus[3], 0);
    tick();
    check("R8 stays clear", rawStatus[3], 0);

    // R7: drain receive, then underflow
    for (int i = 0; i < DEPTH + 1; i++) begin rxPop = 1; tick(); end
    check("R7 rx level floor", rxLevel, 0);
    check("R7 rx underflow flag", rawStatus[2], 1);
    // R2: simultaneous push and pop
    rxPush = 1; tick();
    rxPush = 1; rxPop = 1; tick();
    check("R2 push and pop together", rxLevel, 1);

    // R10 / R11: partial masks
    writeMask(5'h04);
    check("R10 only underflow passes", maskedStatus, 5'h04);
    writeMask(5'h00);
    check("R10 zero mask silences", maskedStatus, 0);
    tick();
    check("R11 irq low after silence", irq, 0);
    writeMask(5'h01);
    tick();
    check("R11 irq from tx empty", irq, 1);

    // R9: depth probe
    probe = 0;
    for (int v = 1; v < 256; v++) begin
      writeThr(0, v);
      if (probe == 0 && txThrRd != 8'(v)) probe = v;
    end
    check("R9 depth probe", probe, DEPTH);
    writeThr(1, 8'hFF);
    check("R9 upper bits zero", rxThrRd, THR_MASK);

    // R12: disable flushes, keeps config, ignores strobes
    writeThr(0, 5);
    for (int i = 0; i < 6; i++) begin txPush = 1; rxPush = 1; tick(); end
    enable = 0; tick();
    check("R12 tx flushed", txLevel, 0);
    check("R12 rx flushed", rxLevel, 0);
    check("R12 errors cleared", rawStatus[3:1], 0);
    txPush = 1; rxPush = 1; tick();
    check("R12 push ignored", txLevel + rxLevel, 0);
    check("R12 thr kept", txThrRd, 5);
    check("R12 mask kept", maskedStatus & 5'h1E, 0);
    enable = 1; tick();

    // mixed pseudo-random traffic
    writeMask(5'h1F);
    lfsr = 32'hACE1;
    for (int n = 0; n < 4000; n++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      txPush   = lfsr[0];
      txPop    = lfsr[1] & lfsr[5];
      rxPush   = lfsr[2] & lfsr[6];
      rxPop    = lfsr[3];
      errClrRd = (lfsr[11:7] == 5'd3);
      enable   = (lfsr[15:8] != 8'd0);
      if (lfsr[14:10] == 5'd1) begin txThrWr = 1; thrWrData = 8'(lfsr); end
      if (lfsr[14:10] == 5'd2) begin rxThrWr = 1; thrWrData = 8'(lfsr >> 3); end
      if (lfsr[14:10] == 5'd4) begin maskWr = 1; maskWrData = 5'(lfsr >> 4); end
      tick();
    end
    enable = 1;
    tick();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule